// File: doc/BRIEF.md
# Producer-consumer latency interlock

This block decides, one cycle at a time, whether the instruction waiting to issue may go now or must be held back. It keeps a small scoreboard with one entry per architectural register. Each entry holds the class of the instruction that last wrote that register and a saturating count of the cycles since that writer issued.

The consumer presents its own class and up to three source operands. Each operand carries a register number, an enable and a usage tag. The usage tag marks the operand as a normal early operand, a late operand (one not needed until the second execute stage, such as a shifted value), a multiply-accumulate accumulator, or the data word of a store. The block turns the producer class, the usage tag and the consumer class into an effective latency for each operand. It stalls when any enabled operand's producer issued too recently. When a consumer is accepted and writes a register, its class and issue time are recorded. The effective latencies also appear on a debug output.

Class codes on `cons_class_i`: 0 ALU, 1 ALU with shift, 2 count leading zeros, 3 move, 4 multiply, 5 multiply-accumulate, 6 long multiply, 7 single-uop multiply, 8 long dual multiply-accumulate, 9 single/double load, 10 load multiple (3 or 4 registers), 11 store, 12 call. Codes 13 to 15 write no register. Usage codes on `src_use_i`: 0 early, 1 late, 2 accumulator, 3 store data.

Top module: `ilk_top`

## Requirements
- R1: After reset, every register reads as having no pending producer. No operand causes a stall, and every enabled operand reports an effective latency of 0.
- R2: For an early operand, the effective latency is the base latency of its producer class. ALU, ALU with shift and count leading zeros have a base latency of 2. Move is 1. Multiply and multiply-accumulate are 6. Long multiply is 7. Single-uop multiply is 5. Long dual multiply-accumulate is 6. Load is 3. Load multiple is 5. Call is 32. Store and codes 13 to 15 are 0.
- R3: Some latencies are reduced for a late operand (usage 1) whose consumer class is 0, 1 or 2. A move producer gives 0. An ALU-type producer (classes 0 to 2) gives 1. Any multiply producer (classes 4 to 8) gives 4. A load gives 2. A load multiple gives 4. Every other producer keeps its base latency.
- R4: An accumulator operand (usage 2) of a multiply-accumulate consumer (class 5) has latency 1 when its producer is class 4, 5 or 7. A long dual multiply-accumulate consumer (class 8) gets no such reduction.
- R5: A store-data operand (usage 3) of a store consumer (class 11) has latency 0 when its producer is class 0 to 3. A store address operand (usage 0) keeps the base latency.
- R6: The distance of an operand is 1 in the cycle after its producer was accepted, and it rises by 1 in each later cycle. While `cons_valid_i` is high, `stall_o` is high exactly when some enabled operand has a distance below its effective latency.
- R7: A register entry is updated only when the consumer is valid, not stalled, has `cons_dst_en_i` set, and its class is one of 0 to 10 or 12. A stalled consumer or a store leaves the scoreboard unchanged.
- R8: The distance saturates at 63, so a producer that was accepted long ago never stalls a consumer. A call result becomes usable exactly 32 cycles after the call was accepted.
- R9: `eff_lat_o` reports each enabled operand's effective latency. A disabled operand reports 0 and never causes a stall.
- R10: `stall_o` is low whenever `cons_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cons_valid_i | input | 1 | A consumer is presented this cycle |
| cons_class_i | input | 4 | Consumer class code |
| cons_dst_en_i | input | 1 | Consumer writes a destination register |
| cons_dst_i | input | 4 | Destination register number |
| src_en_i | input | 3 | Per-operand enable |
| src_reg_i | input | 12 | Per-operand register number, operand 0 in the low bits |
| src_use_i | input | 6 | Per-operand usage code, 2 bits each |
| stall_o | output | 1 | Consumer must not issue this cycle |
| eff_lat_o | output | 18 | Per-operand effective latency, 6 bits each |

## Verification
Directed sequences place one producer of each kind and then hold a dependent consumer against it. The stall is watched until release, so each class's latency is measured as a cycle count rather than read off the debug output. Pairs that differ only in usage tag or consumer class separate the reduced paths from the base path: a late versus an early operand, a multiply-accumulate versus a long dual multiply-accumulate accumulator, and store data versus store address. A stalled consumer with a destination, a long call, and a long idle gap show that no entry is recorded while stalled, that the 32-cycle call wait is exact, and that the counter saturates. Random traffic confined to a few registers then mixes every class and tag against a bench model of the scoreboard.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [3:0] {
    CL_ALU   = 4'd0,
    CL_ALUSH = 4'd1,
    CL_CLZ   = 4'd2,
    CL_MOV   = 4'd3,
    CL_MUL   = 4'd4,
    CL_MLA   = 4'd5,
    CL_MULL  = 4'd6,
    CL_MUL1  = 4'd7,
    CL_DMLAL = 4'd8,
    CL_LD    = 4'd9,
    CL_LDM   = 4'd10,
    CL_ST    = 4'd11,
    CL_CALL  = 4'd12,
    CL_RSV13 = 4'd13,
    CL_RSV14 = 4'd14,
    CL_RSV15 = 4'd15
  } cls_e;

  typedef enum logic [1:0] {
    US_EARLY  = 2'd0,
    US_LATE   = 2'd1,
    US_ACC    = 2'd2,
    US_STDATA = 2'd3
  } use_e;

  localparam int CLS_W = 4;
  localparam int USE_W = 2;

  function automatic logic is_alu(cls_e c);
    return c inside {CL_ALU, CL_ALUSH, CL_CLZ};
  endfunction

  function automatic logic is_mul(cls_e c);
    return c inside {CL_MUL, CL_MLA, CL_MULL, CL_MUL1, CL_DMLAL};
  endfunction

  function automatic logic writes_reg(cls_e c);
    return (c <= CL_LDM) || (c == CL_CALL);
  endfunction

  function automatic int base_lat(cls_e p);
    case (p)
      CL_ALU, CL_ALUSH, CL_CLZ: return 2;
      CL_MOV:                   return 1;
      CL_MUL, CL_MLA, CL_DMLAL: return 6;
      CL_MULL:                  return 7;
      CL_MUL1:                  return 5;
      CL_LD:                    return 3;
      CL_LDM:                   return 5;
      CL_CALL:                  return 32;
      default:                  return 0;
    endcase
  endfunction

  // late-operand reductions for ALU-type consumers
  function automatic int late_lat(cls_e p);
    if (p == CL_MOV) return 0;
    if (is_alu(p))   return 1;
    if (is_mul(p))   return 4;
    if (p == CL_LD)  return 2;
    if (p == CL_LDM) return 4;
    return base_lat(p);
  endfunction

endpackage

// File: rtl/ilk_lat_sel.sv
module ilk_lat_sel
  import ilk_pkg::*;
#(
  parameter int AGE_W = 6
) (
  input  logic             en_i,
  input  logic [CLS_W-1:0] prod_cls_i,
  input  logic [CLS_W-1:0] cons_cls_i,
  input  logic [USE_W-1:0] use_i,
  input  logic [AGE_W-1:0] age_i,
  output logic [AGE_W-1:0] lat_o,
  output logic             wait_o
);

  cls_e p_cls;
  cls_e c_cls;
  use_e u;
  int   lat;

  assign p_cls = cls_e'(prod_cls_i);
  assign c_cls = cls_e'(cons_cls_i);
  assign u     = use_e'(use_i);

  always_comb begin
    lat = base_lat(p_cls);
    unique case (u)
      US_LATE:   if (is_alu(c_cls)) lat = late_lat(p_cls);
      US_ACC:    if (c_cls == CL_MLA && p_cls inside {CL_MUL, CL_MLA, CL_MUL1}) lat = 1;
      US_STDATA: if (c_cls == CL_ST && (is_alu(p_cls) || p_cls == CL_MOV)) lat = 0;
      default:   ;
    endcase
    if (!en_i) lat = 0;
  end

  assign lat_o  = AGE_W'(lat);
  assign wait_o = en_i && (age_i < lat_o);

endmodule

// File: rtl/ilk_sb.sv
module ilk_sb
  import ilk_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int AGE_W = 6,
  parameter int N_RD  = 3,
  parameter int RW    = $clog2(NREG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [RW-1:0]         wr_reg_i,
  input  logic [CLS_W-1:0]      wr_cls_i,
  input  logic [N_RD*RW-1:0]    rd_reg_i,
  output logic [N_RD*AGE_W-1:0] rd_age_o,
  output logic [N_RD*CLS_W-1:0] rd_cls_o
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q [NREG];
  logic [CLS_W-1:0] cls_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) begin
        age_q[r] <= AGE_MAX;
        cls_q[r] <= CLS_W'(CL_ST);
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en_i && wr_reg_i == RW'(r)) begin
          age_q[r] <= AGE_W'(1);
          cls_q[r] <= wr_cls_i;
        end else if (age_q[r] != AGE_MAX) begin
          age_q[r] <= age_q[r] + AGE_W'(1);
        end
      end
    end
  end

  for (genvar i = 0; i < N_RD; i++) begin : g_rd
    assign rd_age_o[i*AGE_W +: AGE_W] = age_q[rd_reg_i[i*RW +: RW]];
    assign rd_cls_o[i*CLS_W +: CLS_W] = cls_q[rd_reg_i[i*RW +: RW]];
  end

endmodule

// File: rtl/ilk_top.sv
module ilk_top
  import ilk_pkg::*;
#(
  parameter int N_SRC = 3,
  parameter int NREG  = 16,
  parameter int AGE_W = 6,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cons_valid_i,
  input  logic [CLS_W-1:0]       cons_class_i,
  input  logic                   cons_dst_en_i,
  input  logic [RW-1:0]          cons_dst_i,
  input  logic [N_SRC-1:0]       src_en_i,
  input  logic [N_SRC*RW-1:0]    src_reg_i,
  input  logic [N_SRC*USE_W-1:0] src_use_i,
  output logic                   stall_o,
  output logic [N_SRC*AGE_W-1:0] eff_lat_o
);

  logic [N_SRC*AGE_W-1:0] rd_age;
  logic [N_SRC*CLS_W-1:0] rd_cls;
  logic [N_SRC-1:0]       op_wait;
  logic                   accept;

  assign accept = cons_valid_i && !stall_o && cons_dst_en_i && writes_reg(cls_e'(cons_class_i));

  ilk_sb #(
    .NREG (NREG),
    .AGE_W(AGE_W),
    .N_RD (N_SRC),
    .RW   (RW)
  ) u_sb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (accept),
    .wr_reg_i(cons_dst_i),
    .wr_cls_i(cons_class_i),
    .rd_reg_i(src_reg_i),
    .rd_age_o(rd_age),
    .rd_cls_o(rd_cls)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_op
    ilk_lat_sel #(.AGE_W(AGE_W)) u_lat (
      .en_i      (src_en_i[i]),
      .prod_cls_i(rd_cls[i*CLS_W +: CLS_W]),
      .cons_cls_i(cons_class_i),
      .use_i     (src_use_i[i*USE_W +: USE_W]),
      .age_i     (rd_age[i*AGE_W +: AGE_W]),
      .lat_o     (eff_lat_o[i*AGE_W +: AGE_W]),
      .wait_o    (op_wait[i])
    );
  end

  assign stall_o = cons_valid_i && (|op_wait);

endmodule

// File: rtl/ilk_chk.sv
module ilk_chk #(
  parameter int N_SRC = 3,
  parameter int AGE_W = 6,
  parameter int RW    = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cons_valid_i,
  input logic [3:0]             cons_class_i,
  input logic                   cons_dst_en_i,
  input logic [RW-1:0]          cons_dst_i,
  input logic [N_SRC-1:0]       src_en_i,
  input logic [N_SRC*RW-1:0]    src_reg_i,
  input logic [N_SRC*2-1:0]     src_use_i,
  input logic                   stall_o,
  input logic [N_SRC*AGE_W-1:0] eff_lat_o
);

  logic any_cause;
  logic lat_big;

  always_comb begin
    any_cause = 1'b0;
    lat_big   = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_en_i[i] && eff_lat_o[i*AGE_W +: AGE_W] != '0) any_cause = 1'b1;
      if (eff_lat_o[i*AGE_W +: AGE_W] > AGE_W'(32)) lat_big = 1'b1;
    end
  end

  a_r10_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cons_valid_i |-> !stall_o);

  a_r6_stall_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> any_cause);

  a_r8_lat_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_big);

  for (genvar i = 0; i < N_SRC; i++) begin : g_off
    a_r9_off_lat_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !src_en_i[i] |-> eff_lat_o[i*AGE_W +: AGE_W] == '0);
  end

  // R6: an accepted multiply blocks an early read of its result in the next cycle
  a_r6_mul_next_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_valid_i && !stall_o && cons_dst_en_i && cons_class_i == 4'd4)
    |=> (!(cons_valid_i && src_en_i[0] && src_reg_i[RW-1:0] == $past(cons_dst_i)
           && src_use_i[1:0] == 2'd0) || stall_o));

endmodule

bind ilk_top ilk_chk #(.N_SRC(N_SRC), .AGE_W(AGE_W), .RW(RW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cons_valid_i (cons_valid_i),
  .cons_class_i (cons_class_i),
  .cons_dst_en_i(cons_dst_en_i),
  .cons_dst_i   (cons_dst_i),
  .src_en_i     (src_en_i),
  .src_reg_i    (src_reg_i),
  .src_use_i    (src_use_i),
  .stall_o      (stall_o),
  .eff_lat_o    (eff_lat_o)
);

// File: tb/sim_ilk_top.sv
module sim_ilk_top;

  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid;
  logic [3:0]  ccls;
  logic        dst_en;
  logic [3:0]  dst;
  logic [2:0]  s_en;
  logic [3:0]  s_reg [N];
  logic [1:0]  s_use [N];
  logic        stall;
  logic [17:0] lat_flat;

  int age_m [16];
  int cls_m [16];
  int vectors = 0;
  int errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ilk_top u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cons_valid_i (valid),
    .cons_class_i (ccls),
    .cons_dst_en_i(dst_en),
    .cons_dst_i   (dst),
    .src_en_i     (s_en),
    .src_reg_i    ({s_reg[2], s_reg[1], s_reg[0]}),
    .src_use_i    ({s_use[2], s_use[1], s_use[0]}),
    .stall_o      (stall),
    .eff_lat_o    (lat_flat)
  );

  function automatic int blat(int p);
    case (p)
      0, 1, 2: return 2;
      3:       return 1;
      4, 5, 8: return 6;
      6:       return 7;
      7:       return 5;
      9:       return 3;
      10:      return 5;
      12:      return 32;
      default: return 0;
    endcase
  endfunction

  function automatic int elat(int p, int cc, int u);
    if (u == 1 && cc <= 2) begin
      if (p == 3) return 0;
      if (p <= 2) return 1;
      if (p >= 4 && p <= 8) return 4;
      if (p == 9) return 2;
      if (p == 10) return 4;
    end
    if (u == 2 && cc == 5 && (p == 4 || p == 5 || p == 7)) return 1;
    if (u == 3 && cc == 11 && p <= 3) return 0;
    return blat(p);
  endfunction

  function automatic string use_tag(int u);
    case (u)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // check at mid-cycle, then advance the model over the next edge
  task automatic step(input string tag);
    bit exp_stall = 0;
    bit bad = 0;
    int el [N];
    #1;
    for (int i = 0; i < N; i++) begin
      el[i] = s_en[i] ? elat(cls_m[s_reg[i]], ccls, s_use[i]) : 0;
      if (valid && s_en[i] && age_m[s_reg[i]] < el[i]) exp_stall = 1;
    end
    vectors++;
    for (int i = 0; i < N; i++) begin
      if (int'(lat_flat[i*6 +: 6]) != el[i]) begin
        bad = 1;
        $display("FAIL %s op%0d lat: actual %0d expected %0d",
                 (tag != "") ? tag : (s_en[i] ? use_tag(s_use[i]) : "R9"),
                 i, lat_flat[i*6 +: 6], el[i]);
      end
    end
    if (stall !== exp_stall) begin
      bad = 1;
      $display("FAIL %s stall: actual %0b expected %0b",
               (tag != "") ? tag : (valid ? "R6" : "R10"), stall, exp_stall);
    end
    if (bad) errs++;
    @(posedge clk);
    for (int r = 0; r < 16; r++) if (age_m[r] < 63) age_m[r]++;
    if (valid && !exp_stall && dst_en && (ccls <= 10 || ccls == 12)) begin
      age_m[dst] = 1;
      cls_m[dst] = ccls;
    end
    @(negedge clk);
  endtask

  task automatic set_cons(input int v, input int c, input int de, input int d);
    valid = v[0]; ccls = c[3:0]; dst_en = de[0]; dst = d[3:0];
  endtask

  task automatic set_op(input int i, input int r, input int u, input int e);
    s_reg[i] = r[3:0]; s_use[i] = u[1:0]; s_en[i] = e[0];
  endtask

  task automatic clear_ops();
    for (int i = 0; i < N; i++) set_op(i, 0, 0, 0);
  endtask

  task automatic produce(input int c, input int d, input string tag);
    set_cons(1, c, 1, d); clear_ops(); step(tag);
  endtask

  // hold a consumer until it issues and compare the wait with the expected latency
  task automatic hold(input int c, input int r, input int u, input int exp_wait, input string tag);
    int n = 0;
    set_cons(1, c, 0, 0); clear_ops(); set_op(0, r, u, 1);
    while (n < 40) begin
      #1;
      if (!stall) break;
      #0 step(tag);
      n++;
    end
    vectors++;
    if (n != exp_wait) begin
      errs++;
      $display("FAIL %s wait cycles: actual %0d expected %0d", tag, n, exp_wait);
    end
    step(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    void'($urandom(seed));
    for (int r = 0; r < 16; r++) begin age_m[r] = 63; cls_m[r] = 11; end
    set_cons(0, 0, 0, 0); clear_ops();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: fresh scoreboard
    set_cons(1, 0, 0, 0);
    set_op(0, 0, 0, 1); set_op(1, 7, 1, 1); set_op(2, 15, 2, 1);
    step("R1");
    set_cons(1, 11, 0, 0); set_op(0, 13, 3, 1); set_op(1, 14, 0, 1);
    step("R1");

    // R2: base latencies measured as wait cycles (wait = latency - 1)
    produce(4, 1, "R2"); hold(0, 1, 0, 5, "R2");
    produce(6, 2, "R2"); hold(0, 2, 0, 6, "R2");
    produce(9, 3, "R2"); hold(0, 3, 0, 2, "R2");
    produce(10, 3, "R2"); hold(3, 3, 1, 4, "R2");
    produce(0, 4, "R2"); hold(0, 4, 0, 1, "R2");
    // R3: late operand on ALU consumer
    produce(3, 2, "R3"); hold(0, 2, 1, 0, "R3");
    produce(7, 2, "R3"); hold(1, 2, 1, 3, "R3");
    produce(9, 2, "R3"); hold(2, 2, 1, 1, "R3");
    // R4: accumulator forwarding
    produce(4, 5, "R4"); hold(5, 5, 2, 0, "R4");
    produce(5, 5, "R4"); hold(8, 5, 2, 5, "R4");
    // R5: store data versus address
    produce(1, 6, "R5"); hold(11, 6, 3, 0, "R5");
    produce(1, 6, "R5"); hold(11, 6, 0, 1, "R5");
    produce(9, 6, "R5"); hold(11, 6, 3, 2, "R5");
    // R7: a stalled consumer records nothing
    produce(4, 8, "R7");
    set_cons(1, 12, 1, 9); clear_ops(); set_op(0, 8, 0, 1); step("R7");
    set_cons(1, 0, 0, 0); clear_ops(); set_op(0, 9, 0, 1); step("R7");
    // R7: a store with destination enable records nothing
    set_cons(1, 11, 1, 9); clear_ops(); step("R7");
    set_cons(1, 0, 0, 0); clear_ops(); set_op(0, 9, 0, 1); step("R7");
    // R8: exact call wait and saturation
    produce(12, 10, "R8"); hold(0, 10, 1, 31, "R8");
    produce(6, 11, "R8");
    set_cons(0, 0, 0, 0); clear_ops();
    repeat (80) step("R8");
    set_cons(1, 0, 0, 0); set_op(0, 11, 0, 1); step("R8");
    // R10: idle with pending producers
    produce(12, 12, "R10");
    set_cons(0, 0, 0, 0); clear_ops(); set_op(0, 12, 0, 1); set_op(1, 12, 1, 1);
    step("R10");
    // R9: disabled operand on a pending register
    set_cons(1, 0, 0, 0); clear_ops(); set_op(0, 12, 0, 0); step("R9");

    // random traffic on a few registers
    for (int k = 0; k < 3000; k++) begin
      set_cons(($urandom % 5) != 0, $urandom % 16, $urandom % 2, $urandom % 4);
      for (int i = 0; i < N; i++) set_op(i, $urandom % 4, $urandom % 4, $urandom % 2);
      step("");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule